// File: doc/BRIEF.md
# Vernier Time-to-Digital Converter Capture Decoder

This block is the digital back end of a Vernier delay-line time-to-digital converter. The analog line holds one flip-flop per stage: the start edge travels down the slow line and drives each flip-flop's data, and the stop edge travels down the fast line and clocks it. Each stage the stop edge passes while still behind the start edge latches a one. Once the stop edge has caught up, the remaining stages latch zeros. When the line reports that a measurement has finished, the block stores the stage vector and finds the catch-up stage. It then reports that stage and the matching interval in picoseconds.

The block also routes the start and stop events into the line. They come either from the on-chip charge-pump comparators or from two external pins, and the external path lets the converter be tested on its own. A channel select decides whether the sensing capacitor path or the reference capacitor path supplies the internal stop event. A mode input switches between measuring and readout. In readout, each rising edge of a slow external data clock places the next stored stage bit on a serial pin, starting with stage 0.

Top module: `vtdc_readout`

## Requirements
- R1: After reset, code_valid, stage_idx, time_ps, overflow, sdata and sdone are all 0.
- R2: A cap_valid strobe sampled while run_mode is 0 is ignored. code_valid stays 0, and a later serial readout still shows the stage vector stored before the strobe.
- R3: While run_mode is 1, a cap_valid strobe sampled at a clock edge stores stage_q (bit i is stage i, 1 = stop still behind start). code_valid is 1 for exactly the clock cycle after the next edge. stage_idx equals the count of ones in the stored vector, which for a clean vector 0..01..1 is the index of its lowest zero. An all-zero vector gives 0.
- R4: If a vector has one bubble, with the stage just below the true transition reading 0 and the stage at the transition reading 1, it decodes to the same stage_idx as the clean vector.
- R5: An all-ones vector (no transition anywhere in the STAGES stages) sets overflow to 1 and gives stage_idx = STAGES. Every other vector gives overflow = 0.
- R6: time_ps equals stage_idx multiplied by RES_PS (default 30 ps per stage), so an interval t with d·RES_PS ≤ t < (d+1)·RES_PS reads back as d·RES_PS.
- R7: While run_mode is 0, the k-th rising edge of dclk (k = 0 first) sets sdata to bit k of the stored vector. A dclk edge is seen by the block SYNC_STAGES+1 clock edges after it arrives.
- R8: sdone rises once STAGES bits have been shifted out. Further dclk edges then change neither sdata nor sdone. Setting run_mode to 1 clears sdone and sdata and restarts the next readout at stage 0.
- R9: With int_src_en at 1, line_start follows int_start. With it at 0, line_start and line_stop follow ext_start and ext_stop, and the internal events are blocked.
- R10: With int_src_en at 1, line_stop follows stop_sense when ref_sel is 0 and stop_ref when ref_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_mode | input | 1 | 1 = measure and capture, 0 = serial readout |
| int_src_en | input | 1 | 1 = internal start/stop events, 0 = external pins |
| ref_sel | input | 1 | 0 = sensing path stop, 1 = reference path stop |
| int_start | input | 1 | Internally generated start event |
| stop_sense | input | 1 | Stop event from the sensing capacitor comparator |
| stop_ref | input | 1 | Stop event from the reference capacitor comparator |
| ext_start | input | 1 | External start event for stand-alone test |
| ext_stop | input | 1 | External stop event for stand-alone test |
| line_start | output | 1 | Start event driven into the slow delay line |
| line_stop | output | 1 | Stop event driven into the fast delay line |
| stage_q | input | STAGES | Stage flip-flop outputs, bit i = stage i |
| cap_valid | input | 1 | Strobe: stage_q holds a finished measurement |
| code_valid | output | 1 | One-cycle pulse: decoded result updated |
| stage_idx | output | IDX_W | Decoded catch-up stage |
| time_ps | output | TIME_W | Interval in picoseconds |
| overflow | output | 1 | No transition found in the line |
| dclk | input | 1 | External data clock for serial readout |
| sdata | output | 1 | Serial stage bit |
| sdone | output | 1 | All stage bits have been shifted out |

## Verification
The bench builds stage vectors from start–stop intervals at 30 ps per stage. It covers the documented 300 to 900 ps points, intervals just below and at a stage boundary, the zero interval, and intervals past the end of the line. A decoder that searched for the first zero instead of counting ones would fail the bubbled vectors. An overflow test off by one would miss the exact all-ones vector or flag an interval of 930 ps. The bench reads the whole vector out serially and then sends extra data-clock edges. A readout that shifted out the highest stage first, skipped stage 0, or kept counting past the last stage would show a wrong bit or a sdone that drops. It also strobes a capture during readout mode; a block that captured anyway would pulse code_valid or change the bits it reads back.

// File: rtl/vtdc_pkg.sv
package vtdc_pkg;
   typedef enum logic {
      MODE_READOUT = 1'b0,
      MODE_RUN     = 1'b1
   } vtdc_mode_e;

   typedef enum logic {
      SRC_EXTERNAL = 1'b0,
      SRC_INTERNAL = 1'b1
   } vtdc_src_e;

   localparam int VTDC_MAX_STAGES = 256;
endpackage

// File: rtl/vtdc_src_mux.sv
module vtdc_src_mux
   import vtdc_pkg::*;
(
   input  logic src_sel,
   input  logic ref_sel,
   input  logic int_start,
   input  logic stop_sense,
   input  logic stop_ref,
   input  logic ext_start,
   input  logic ext_stop,
   output logic line_start,
   output logic line_stop
);
   logic int_stop;

   // channel pick happens before the source pick, so the external path
   // never sees either comparator
   assign int_stop = ref_sel ? stop_ref : stop_sense;

   always_comb begin
      if (vtdc_src_e'(src_sel) == SRC_INTERNAL) begin
         line_start = int_start;
         line_stop  = int_stop;
      end else begin
         line_start = ext_start;
         line_stop  = ext_stop;
      end
   end
endmodule

// File: rtl/vtdc_decode.sv
module vtdc_decode #(
   parameter int STAGES = 32,
   parameter int RES_PS = 30,
   parameter int IDX_W  = $clog2(STAGES + 1),
   parameter int TIME_W = IDX_W + $clog2(RES_PS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [STAGES-1:0] stage_q,
   output logic [STAGES-1:0] cap_q,
   output logic              code_valid,
   output logic [IDX_W-1:0]  stage_idx,
   output logic [TIME_W-1:0] time_ps,
   output logic              overflow
);
   logic             pend_q;
   logic [IDX_W-1:0] ones;
   logic             all_ones;

   // capture register: stage vector frozen at the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= load;
         if (load) cap_q <= stage_q;
      end
   end

   // ones count: equals the lowest-zero index for a clean vector and
   // absorbs a swapped pair at the transition
   always_comb begin
      ones = '0;
      for (int i = 0; i < STAGES; i++) ones = ones + IDX_W'(cap_q[i]);
   end

   assign all_ones = &cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_valid <= 1'b0;
         stage_idx  <= '0;
         time_ps    <= '0;
         overflow   <= 1'b0;
      end else begin
         code_valid <= pend_q;
         if (pend_q) begin
            stage_idx <= ones;
            time_ps   <= TIME_W'(ones) * TIME_W'(RES_PS);
            overflow  <= all_ones;
         end
      end
   end
endmodule

// File: rtl/vtdc_serout.sv
module vtdc_serout
   import vtdc_pkg::*;
#(
   parameter int STAGES      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = $clog2(STAGES + 1),
   parameter int SEL_W       = $clog2(STAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_mode,
   input  logic              dclk,
   input  logic [STAGES-1:0] cap_q,
   output logic              sdata,
   output logic              sdone
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   dclk_rise;
   logic [IDX_W-1:0]       cnt_q;
   logic                   in_readout;

   // data clock is asynchronous: bring it in through a flop chain
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= dclk;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];

   assign dclk_rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
   assign in_readout = (vtdc_mode_e'(run_mode) == MODE_READOUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sdata <= 1'b0;
         sdone <= 1'b0;
      end else if (!in_readout) begin
         cnt_q <= '0;
         sdata <= 1'b0;
         sdone <= 1'b0;
      end else if (dclk_rise && (cnt_q < IDX_W'(STAGES))) begin
         sdata <= cap_q[cnt_q[SEL_W-1:0]];
         cnt_q <= cnt_q + 1'b1;
         sdone <= (cnt_q == IDX_W'(STAGES - 1));
      end
   end
endmodule

// File: rtl/vtdc_readout.sv
module vtdc_readout
   import vtdc_pkg::*;
#(
   parameter int STAGES      = 32,
   parameter int RES_PS      = 30,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = $clog2(STAGES + 1),
   parameter int TIME_W      = IDX_W + $clog2(RES_PS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_mode,
   input  logic              int_src_en,
   input  logic              ref_sel,
   input  logic              int_start,
   input  logic              stop_sense,
   input  logic              stop_ref,
   input  logic              ext_start,
   input  logic              ext_stop,
   output logic              line_start,
   output logic              line_stop,
   input  logic [STAGES-1:0] stage_q,
   input  logic              cap_valid,
   output logic              code_valid,
   output logic [IDX_W-1:0]  stage_idx,
   output logic [TIME_W-1:0] time_ps,
   output logic              overflow,
   input  logic              dclk,
   output logic              sdata,
   output logic              sdone
);
   localparam int SEL_W = $clog2(STAGES);

   generate
      if (STAGES < 2 || STAGES > VTDC_MAX_STAGES) begin : g_bad_stages
         $error("vtdc_readout: STAGES out of range");
      end
      if (RES_PS < 1) begin : g_bad_res
         $error("vtdc_readout: RES_PS must be positive");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("vtdc_readout: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              load;
   logic [STAGES-1:0] cap_q;

   assign load = cap_valid && (vtdc_mode_e'(run_mode) == MODE_RUN);

   vtdc_src_mux u_src (
      .src_sel    (int_src_en),
      .ref_sel    (ref_sel),
      .int_start  (int_start),
      .stop_sense (stop_sense),
      .stop_ref   (stop_ref),
      .ext_start  (ext_start),
      .ext_stop   (ext_stop),
      .line_start (line_start),
      .line_stop  (line_stop)
   );

   vtdc_decode #(
      .STAGES (STAGES),
      .RES_PS (RES_PS),
      .IDX_W  (IDX_W),
      .TIME_W (TIME_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .stage_q    (stage_q),
      .cap_q      (cap_q),
      .code_valid (code_valid),
      .stage_idx  (stage_idx),
      .time_ps    (time_ps),
      .overflow   (overflow)
   );

   vtdc_serout #(
      .STAGES      (STAGES),
      .SYNC_STAGES (SYNC_STAGES),
      .IDX_W       (IDX_W),
      .SEL_W       (SEL_W)
   ) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_mode (run_mode),
      .dclk     (dclk),
      .cap_q    (cap_q),
      .sdata    (sdata),
      .sdone    (sdone)
   );
endmodule

// File: rtl/vtdc_readout_chk.sv
module vtdc_readout_chk #(
   parameter int STAGES = 32,
   parameter int RES_PS = 30,
   parameter int IDX_W  = $clog2(STAGES + 1),
   parameter int TIME_W = IDX_W + $clog2(RES_PS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_mode,
   input logic              int_src_en,
   input logic              int_start,
   input logic              ext_start,
   input logic              line_start,
   input logic              cap_valid,
   input logic              code_valid,
   input logic [IDX_W-1:0]  stage_idx,
   input logic [TIME_W-1:0] time_ps,
   input logic              overflow,
   input logic              sdone
);
   // R3: a strobe in run mode yields a result on the following edge
   a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (run_mode && cap_valid) |=> ##1 code_valid);

   // R2: no result while readout mode has held for two edges
   a_r2_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_mode && $past(!run_mode) && $past(!run_mode, 2)) |-> !code_valid);

   // R5: overflow implies the full stage count
   a_r5_overflow_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && overflow) |-> (stage_idx == IDX_W'(STAGES)));

   // R6: the time code tracks the stage code
   a_r6_time_scale: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |-> (time_ps == TIME_W'(stage_idx) * TIME_W'(RES_PS)));

   // R8: done holds through readout
   a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sdone && !run_mode) |=> (sdone || run_mode));

   // R9: an internal start cannot leak onto the line in external mode
   a_r9_int_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_src_en && int_start && !ext_start) |-> !line_start);
endmodule

bind vtdc_readout vtdc_readout_chk #(
   .STAGES (STAGES),
   .RES_PS (RES_PS),
   .IDX_W  (IDX_W),
   .TIME_W (TIME_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run_mode   (run_mode),
   .int_src_en (int_src_en),
   .int_start  (int_start),
   .ext_start  (ext_start),
   .line_start (line_start),
   .cap_valid  (cap_valid),
   .code_valid (code_valid),
   .stage_idx  (stage_idx),
   .time_ps    (time_ps),
   .overflow   (overflow),
   .sdone      (sdone)
);

// File: tb/tb_vtdc_readout.sv
`timescale 1ns/1ps
module tb_vtdc_readout;
   localparam int STAGES = 32;
   localparam int RES    = 30;
   localparam int IDX_W  = 6;
   localparam int TIME_W = 11;
   localparam int NV     = 14;
   localparam int T_PS [NV] = '{0, 29, 30, 300, 450, 600, 750, 900,
                                929, 930, 960, 2000, 455, 610};
   localparam bit BUB  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                0, 0, 0, 0, 1, 1};

   logic clk = 0, rst_n = 0;
   logic run_mode = 1, int_src_en = 1, ref_sel = 0;
   logic int_start = 0, stop_sense = 0, stop_ref = 0, ext_start = 0, ext_stop = 0;
   logic line_start, line_stop;
   logic [STAGES-1:0] stage_q = '0;
   logic cap_valid = 0;
   logic code_valid, overflow, dclk = 0, sdata, sdone;
   logic [IDX_W-1:0] stage_idx;
   logic [TIME_W-1:0] time_ps;

   int nchk = 0, nfail = 0;
   logic [STAGES-1:0] last_vec;

   always #2 clk = ~clk;

   vtdc_readout dut (.*);

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [STAGES-1:0] mk_vec(input int t, input bit bub);
      int n = t / RES;
      logic [STAGES-1:0] v;
      if (n >= STAGES) return '1;
      v = STAGES'((64'd1 << n) - 1);
      if (bub && n >= 2 && n < STAGES - 1) begin
         v[n-1] = 1'b0;
         v[n]   = 1'b1;
      end
      return v;
   endfunction

   task automatic strobe(input logic [STAGES-1:0] v);
      @(negedge clk); stage_q = v; cap_valid = 1;
      @(negedge clk); cap_valid = 0; stage_q = '0;
   endtask

   task automatic pulse_dclk();
      @(negedge clk); dclk = 1;
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic drop_dclk();
      @(negedge clk); dclk = 0;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 code_valid", code_valid, 0);
      chk("R1 stage_idx", stage_idx, 0);
      chk("R1 time_ps", time_ps, 0);
      chk("R1 overflow", overflow, 0);
      chk("R1 sdata", sdata, 0);
      chk("R1 sdone", sdone, 0);
      @(negedge clk) rst_n = 1;

      // table: R3 R4 R5 R6
      for (int k = 0; k < NV; k++) begin
         logic [STAGES-1:0] v = mk_vec(T_PS[k], BUB[k]);
         int n = (T_PS[k] / RES >= STAGES) ? STAGES : T_PS[k] / RES;
         strobe(v);
         @(posedge clk); #1;
         chk("R3 code_valid", code_valid, 1);
         chk(BUB[k] ? "R4 stage_idx bubble" : "R3 stage_idx", stage_idx, n);
         chk("R5 overflow", overflow, (n == STAGES) ? 1 : 0);
         chk("R6 time_ps", time_ps, n * RES);
         @(posedge clk); #1;
         chk("R3 code_valid pulse width", code_valid, 0);
      end

      // capture a pattern with distinct stage bits for readout, R7 R8
      last_vec = 32'hA5C3_0F1E;
      strobe(last_vec);
      repeat (2) @(posedge clk);
      @(negedge clk) run_mode = 0;
      for (int b = 0; b < STAGES; b++) begin
         pulse_dclk();
         chk("R7 serial bit", sdata, last_vec[b]);
         chk("R8 done timing", sdone, (b == STAGES - 1) ? 1 : 0);
         drop_dclk();
      end
      pulse_dclk();
      chk("R8 extra edge sdone", sdone, 1);
      chk("R8 extra edge sdata", sdata, last_vec[STAGES-1]);
      drop_dclk();

      // R2: strobe in readout mode is ignored
      @(negedge clk); stage_q = '0; cap_valid = 1;
      @(negedge clk); cap_valid = 0;
      @(posedge clk); #1;
      chk("R2 no code_valid", code_valid, 0);
      @(posedge clk); #1;
      chk("R2 no code_valid later", code_valid, 0);
      @(negedge clk) run_mode = 1;
      @(posedge clk); #1;
      chk("R8 sdone cleared", sdone, 0);
      @(negedge clk) run_mode = 0;
      for (int b = 0; b < 4; b++) begin
         pulse_dclk();
         chk("R2 old capture kept", sdata, last_vec[b]);
         drop_dclk();
      end
      @(negedge clk) run_mode = 1;

      // R9 R10 source and channel selection
      @(negedge clk);
      int_src_en = 1; ref_sel = 0; int_start = 1; stop_sense = 1; stop_ref = 0;
      ext_start = 0; ext_stop = 0; #1;
      chk("R9 internal start", line_start, 1);
      chk("R10 sense stop", line_stop, 1);
      ref_sel = 1; #1;
      chk("R10 ref stop", line_stop, 0);
      stop_ref = 1; stop_sense = 0; #1;
      chk("R10 ref stop high", line_stop, 1);
      int_src_en = 0; #1;
      chk("R9 internal start blocked", line_start, 0);
      chk("R9 internal stop blocked", line_stop, 0);
      ext_start = 1; ext_stop = 1; int_start = 0; stop_ref = 0; #1;
      chk("R9 external start", line_start, 1);
      chk("R9 external stop", line_stop, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule